// File: doc/BRIEF.md
# Link-Level Flow Control, Transmit Side

This block sits on the sending end of one router output port that carries several virtual channels (VCs). It decides, for each VC, whether a flit may be launched onto the link this cycle. It keeps the receiver's buffers from overflowing, and it does so without a full handshake on every flit.

A parameter selects one of two schemes, and both drive the same per-VC `can_send_o` vector. In credit mode, the block keeps one counter per VC that mirrors the free slots in the receiver's buffer for that VC. A launched flit takes one slot. A credit coming back from the receiver gives one slot back, after a configurable number of return-path register stages. In stop/go mode there are no counters. The block follows a per-VC go level from the receiver, delayed by the same return-path stages. The receiver drops that level once its buffer fill reaches an off level.

A companion receiver occupancy model, `lfc_rx_occ`, produces that go level from arrivals and drains. Its off level must leave room for the flits still on the wire.

Top module: `link_fc_tx`

## Requirements
- R1: After reset, every credit counter holds BUF_DEPTH, every bit of `can_send_o` is 1 and `ovf_o` is 0. In stop/go mode the delayed go levels also reset to 1.
- R2: In credit mode, `can_send_o[v]` is 1 exactly when the counter of VC v is above zero, and `xon_i` has no effect.
- R3: A send (`send_i`=1, VC `send_vc_i`) is accepted only when `can_send_o` of that VC is 1. An accepted send lowers that VC's counter by one at the next clock edge. A send that is not accepted, or that names a VC number of NUM_VC or more, changes nothing.
- R4: A credit strobe (`cred_i`=1, VC `cred_vc_i`) passes through RET_STAGES register stages and then raises that VC's counter by one at the following edge. With RET_STAGES=1, the counter is visible two edges after the strobe cycle.
- R5: When an accepted send and an arriving credit hit the same VC in one cycle, that counter is unchanged. When they hit different VCs, each change applies to its own VC.
- R6: A credit that arrives while its VC's counter is at BUF_DEPTH, with no accepted send on that VC in the same cycle, sets `ovf_o`. `ovf_o` stays 1 until reset, and the counter stays at BUF_DEPTH.
- R7: In stop/go mode, `can_send_o` equals `xon_i` delayed by RET_STAGES cycles. In this mode the send and credit inputs have no effect, and `ovf_o` stays 0.
- R8: In `lfc_rx_occ`, an arrival raises the fill of its VC by one and a drain lowers it by one. A drain at fill zero is ignored. `xon_o[v]` is 1 exactly when the fill of VC v is below OFF_LEVEL.
- R9: Elaboration requires OFF_LEVEL + INFLIGHT ≤ DEPTH. A stop/go transmitter with RET_STAGES = INFLIGHT, feeding an undrained receiver VC every cycle, gets exactly OFF_LEVEL + RET_STAGES flits accepted. The receiver's overflow flag stays 0.
- R10: Elaboration requires BUF_DEPTH ≥ LINK_RTT in credit mode. A stream that launches a flit on one VC every cycle never stalls when each credit comes back within LINK_RTT cycles. It does stall when the credit loop is longer than BUF_DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| send_i | input | 1 | Request to launch a flit this cycle |
| send_vc_i | input | VCW | VC of the launched flit |
| cred_i | input | 1 | Credit returned by the receiver (credit mode) |
| cred_vc_i | input | VCW | VC the credit belongs to |
| xon_i | input | NUM_VC | Per-VC go level from the receiver (stop/go mode) |
| can_send_o | output | NUM_VC | Per-VC permission to launch a flit |
| ovf_o | output | 1 | Sticky credit-overflow error |

## Verification
The credit side is first exercised with directed patterns. A draining run separates a decrement from an ignored send. A single returned credit exposes the return-path latency. A same-cycle send and credit, on one VC and then on two VCs, separates a net-zero update from a lost one. A credit into a full counter separates overflow detection from silent wrap. A long pseudo-random run with only legal credits then compares `can_send_o` every cycle against an arithmetic model of each counter. Continuous streams with credits returned one and two cycles late separate a loop that hides the latency from one that stalls. The stop/go side is closed through the receiver model and driven with undrained streams, drains across the off level, drains of an empty VC and stray credit strobes. These show the in-flight margin, the threshold edge and input isolation, each tied to an exact count of accepted flits.

// File: rtl/lfc_pkg.sv
package lfc_pkg;

   typedef enum logic {
      FC_CREDIT = 1'b0,
      FC_ONOFF  = 1'b1
   } fc_mode_e;

   function automatic int unsigned idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/lfc_pipe.sv
module lfc_pipe #(
   parameter int          W       = 1,
   parameter int          STAGES  = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 0) begin : g_bad_stages
      $error("lfc_pipe: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_wire
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign q = d;
   end else begin : g_regs
      logic [W-1:0] stg [STAGES];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
         end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         end
      end
      assign q = stg[STAGES-1];
   end

endmodule

// File: rtl/lfc_credit_ctr.sv
module lfc_credit_ctr #(
   parameter int DEPTH = 8,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic take_i,
   input  logic give_i,
   output logic avail_o,
   output logic ovf_o
);

   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   logic [CW-1:0] cnt_q;
   logic          taken;
   logic          at_full;

   assign avail_o = (cnt_q != '0);
   assign taken   = take_i && avail_o;
   assign at_full = (cnt_q == FULL);
   assign ovf_o   = give_i && at_full && !taken;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= FULL;
      end else begin
         unique case ({give_i, taken})
            2'b10:   if (!at_full) cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

endmodule

// File: rtl/lfc_rx_occ.sv
module lfc_rx_occ #(
   parameter int NUM_VC    = 4,
   parameter int DEPTH     = 8,
   parameter int OFF_LEVEL = 6,
   parameter int INFLIGHT  = 2,
   localparam int VCW      = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
   localparam int OW       = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arr_i,
   input  logic [VCW-1:0]    arr_vc_i,
   input  logic              drain_i,
   input  logic [VCW-1:0]    drain_vc_i,
   output logic [NUM_VC-1:0] xon_o,
   output logic              full_err_o
);

   if (OFF_LEVEL < 1) begin : g_bad_off
      $error("lfc_rx_occ: OFF_LEVEL must be at least 1");
   end
   if (OFF_LEVEL + INFLIGHT > DEPTH) begin : g_bad_margin
      $error("lfc_rx_occ: OFF_LEVEL leaves no room for flits in flight");
   end

   localparam logic [OW-1:0] FULL = OW'(DEPTH);
   localparam logic [OW-1:0] OFFV = OW'(OFF_LEVEL);

   logic [NUM_VC-1:0] err_v;

   for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
      logic [OW-1:0] fill_q;
      logic          in_hit;
      logic          out_hit;

      assign in_hit  = arr_i && (arr_vc_i == VCW'(v));
      assign out_hit = drain_i && (drain_vc_i == VCW'(v)) && (fill_q != '0);
      assign err_v[v] = in_hit && !out_hit && (fill_q == FULL);
      assign xon_o[v] = (fill_q < OFFV);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            fill_q <= '0;
         end else begin
            unique case ({in_hit, out_hit})
               2'b10:   if (fill_q != FULL) fill_q <= fill_q + 1'b1;
               2'b01:   fill_q <= fill_q - 1'b1;
               default: fill_q <= fill_q;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) full_err_o <= 1'b0;
      else        full_err_o <= full_err_o | (|err_v);
   end

endmodule

// File: rtl/link_fc_tx.sv
module link_fc_tx
   import lfc_pkg::*;
#(
   parameter int       NUM_VC     = 4,
   parameter int       BUF_DEPTH  = 8,
   parameter int       RET_STAGES = 1,
   parameter int       LINK_RTT   = 4,
   parameter fc_mode_e MODE       = FC_CREDIT,
   localparam int      VCW        = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              send_i,
   input  logic [VCW-1:0]    send_vc_i,
   input  logic              cred_i,
   input  logic [VCW-1:0]    cred_vc_i,
   input  logic [NUM_VC-1:0] xon_i,
   output logic [NUM_VC-1:0] can_send_o,
   output logic              ovf_o
);

   if (NUM_VC < 1) begin : g_bad_vc
      $error("link_fc_tx: NUM_VC must be at least 1");
   end
   if (BUF_DEPTH < 1) begin : g_bad_depth
      $error("link_fc_tx: BUF_DEPTH must be at least 1");
   end
   if (LINK_RTT < RET_STAGES + 1) begin : g_bad_rtt
      $error("link_fc_tx: LINK_RTT shorter than the return path");
   end
   if (MODE == FC_CREDIT && BUF_DEPTH < LINK_RTT) begin : g_bad_cover
      $error("link_fc_tx: BUF_DEPTH does not cover the credit round trip");
   end

   // Delayed credit as seen by the counters; the checker also watches it.
   logic           ret_hit_v;
   logic [VCW-1:0] ret_vc_w;

   if (MODE == FC_CREDIT) begin : g_credit
      logic [NUM_VC-1:0] ovf_v;
      logic              ovf_q;
      logic              unused_xon;

      assign unused_xon = ^xon_i;

      lfc_pipe #(
         .W      (VCW + 1),
         .STAGES (RET_STAGES),
         .RST_VAL('0)
      ) u_ret (
         .clk  (clk),
         .rst_n(rst_n),
         .d    ({cred_i, cred_vc_i}),
         .q    ({ret_hit_v, ret_vc_w})
      );

      for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
         lfc_credit_ctr #(.DEPTH(BUF_DEPTH)) u_ctr (
            .clk    (clk),
            .rst_n  (rst_n),
            .take_i (send_i && (send_vc_i == VCW'(v))),
            .give_i (ret_hit_v && (ret_vc_w == VCW'(v))),
            .avail_o(can_send_o[v]),
            .ovf_o  (ovf_v[v])
         );
      end

      always_ff @(posedge clk) begin
         if (!rst_n) ovf_q <= 1'b0;
         else        ovf_q <= ovf_q | (|ovf_v);
      end
      assign ovf_o = ovf_q;

   end else begin : g_onoff
      logic unused_tx;

      assign unused_tx = ^{send_i, send_vc_i, cred_i, cred_vc_i};
      assign ret_hit_v = 1'b0;
      assign ret_vc_w  = '0;

      lfc_pipe #(
         .W      (NUM_VC),
         .STAGES (RET_STAGES),
         .RST_VAL({NUM_VC{1'b1}})
      ) u_xon (
         .clk  (clk),
         .rst_n(rst_n),
         .d    (xon_i),
         .q    (can_send_o)
      );

      assign ovf_o = 1'b0;
   end

endmodule

// File: rtl/lfc_tx_chk.sv
module lfc_tx_chk #(
   parameter int NUM_VC    = 4,
   parameter int VCW       = 2,
   parameter bit IS_CREDIT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              send_i,
   input logic [VCW-1:0]    send_vc_i,
   input logic [NUM_VC-1:0] can_send_o,
   input logic              ovf_o,
   input logic              ret_v,
   input logic [VCW-1:0]    ret_vc
);

   // R6
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> ovf_o);

   if (IS_CREDIT) begin : g_credit
      // R6
      ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ovf_o) |-> $past(ret_v));

      for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
         // R3
         drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(can_send_o[v]) |-> $past(send_i && send_vc_i == VCW'(v)));
         // R4
         rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(can_send_o[v]) |-> $past(ret_v && ret_vc == VCW'(v)));
      end
   end else begin : g_onoff
      // R7
      onoff_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !ovf_o);
   end

endmodule

bind link_fc_tx lfc_tx_chk #(
   .NUM_VC   (NUM_VC),
   .VCW      (VCW),
   .IS_CREDIT(MODE == lfc_pkg::FC_CREDIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .send_i    (send_i),
   .send_vc_i (send_vc_i),
   .can_send_o(can_send_o),
   .ovf_o     (ovf_o),
   .ret_v     (ret_hit_v),
   .ret_vc    (ret_vc_w)
);

// File: tb/tb_link_fc_tx.sv
`timescale 1ns/1ps
module tb_link_fc_tx;
   import lfc_pkg::*;

   localparam int CD = 3;   // credit-side buffer depth
   localparam int OD = 4;   // receiver depth, stop/go side
   localparam int OFF = 3;  // receiver off level

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   // credit-mode instance
   logic       send_c, cred_c;
   logic [1:0] svc_c, cvc_c;
   logic [2:0] xon_c, can_c;
   logic       ovf_c;
   // stop/go instance
   logic       send_o, cred_o, drain_o;
   logic       svc_o, cvc_o, dvc_o;
   logic [1:0] xon_w, can_o;
   logic       ovf_ow, ferr, arr_o;

   link_fc_tx #(.NUM_VC(3), .BUF_DEPTH(CD), .RET_STAGES(1), .LINK_RTT(3),
                .MODE(FC_CREDIT)) dut (
      .clk(clk), .rst_n(rst_n), .send_i(send_c), .send_vc_i(svc_c),
      .cred_i(cred_c), .cred_vc_i(cvc_c), .xon_i(xon_c),
      .can_send_o(can_c), .ovf_o(ovf_c));

   link_fc_tx #(.NUM_VC(2), .BUF_DEPTH(OD), .RET_STAGES(1), .LINK_RTT(2),
                .MODE(FC_ONOFF)) dut_oo (
      .clk(clk), .rst_n(rst_n), .send_i(send_o), .send_vc_i(svc_o),
      .cred_i(cred_o), .cred_vc_i(cvc_o), .xon_i(xon_w),
      .can_send_o(can_o), .ovf_o(ovf_ow));

   assign arr_o = send_o && can_o[svc_o];

   lfc_rx_occ #(.NUM_VC(2), .DEPTH(OD), .OFF_LEVEL(OFF), .INFLIGHT(1)) rxm (
      .clk(clk), .rst_n(rst_n), .arr_i(arr_o), .arr_vc_i(svc_o),
      .drain_i(drain_o), .drain_vc_i(dvc_o), .xon_o(xon_w), .full_err_o(ferr));

   // staged stimulus, copied onto the pins at the falling edge
   logic       s_send_c, s_cred_c, s_send_o, s_cred_o, s_drain;
   logic [1:0] s_svc_c, s_cvc_c;
   logic       s_svc_o, s_cvc_o, s_dvc;

   // arithmetic models
   int   ecnt [3];
   logic eovf, pv;
   logic [1:0] pvc;
   int   eocc [2];
   logic [1:0] exq;
   logic c_acc, o_acc;

   int n_chk = 0, n_fail = 0;
   int unsigned seed = 32'h1234_5678;
   bit done = 0;

   function automatic int unsigned rnd();
      seed = seed * 32'd1103515245 + 32'd12345;
      return seed >> 16;
   endfunction

   task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h at %0t", rq, act, exp, $time);
      end
   endtask

   task automatic idle();
      s_send_c = 0; s_cred_c = 0; s_svc_c = 0; s_cvc_c = 0;
      s_send_o = 0; s_cred_o = 0; s_drain = 0; s_svc_o = 0; s_cvc_o = 0; s_dvc = 0;
   endtask

   task automatic tick(input string rq_c, input string rq_o);
      logic [2:0] ec;
      logic [1:0] nx;
      @(negedge clk);
      send_c = s_send_c; svc_c = s_svc_c; cred_c = s_cred_c; cvc_c = s_cvc_c;
      xon_c  = 3'(rnd());
      send_o = s_send_o; svc_o = s_svc_o; cred_o = s_cred_o; cvc_o = s_cvc_o;
      drain_o = s_drain; dvc_o = s_dvc;
      #1;
      for (int v = 0; v < 3; v++) ec[v] = (ecnt[v] > 0);
      chk(rq_c, {5'b0, can_c}, {5'b0, ec});
      chk(rq_c, {7'b0, ovf_c}, {7'b0, eovf});
      chk(rq_o, {6'b0, can_o}, {6'b0, exq});
      chk({rq_o, " R9"}, {6'b0, ovf_ow, ferr}, 8'h00);
      c_acc = send_c && (svc_c < 3) && can_c[svc_c];
      o_acc = send_o && can_o[svc_o];
      for (int v = 0; v < 3; v++) begin
         automatic bit inc = pv && (pvc == 2'(v));
         automatic bit dec = send_c && (svc_c == 2'(v)) && (ecnt[v] > 0);
         if (inc && !dec && ecnt[v] == CD) eovf = 1;
         else ecnt[v] = ecnt[v] + int'(inc) - int'(dec);
      end
      pv = cred_c; pvc = cvc_c;
      for (int v = 0; v < 2; v++) begin
         automatic bit ar = send_o && (svc_o == 1'(v)) && exq[v];
         automatic bit dn = drain_o && (dvc_o == 1'(v)) && (eocc[v] > 0);
         nx[v] = (eocc[v] < OFF);
         eocc[v] = eocc[v] + int'(ar) - int'(dn);
      end
      exq = nx;
      @(posedge clk);
   endtask

   task automatic do_reset();
      idle();
      @(negedge clk);
      rst_n = 0;
      send_c = 0; cred_c = 0; svc_c = 0; cvc_c = 0; xon_c = 0;
      send_o = 0; cred_o = 0; drain_o = 0; svc_o = 0; cvc_o = 0; dvc_o = 0;
      repeat (3) @(posedge clk);
      for (int v = 0; v < 3; v++) ecnt[v] = CD;
      for (int v = 0; v < 2; v++) eocc[v] = 0;
      eovf = 0; pv = 0; pvc = 0; exq = 2'b11;
      @(negedge clk);
      rst_n = 1;
   endtask

   // launches on one credit VC until refused; result = accepted count
   task automatic drain_c(input logic [1:0] vc, input string rq, input int exp_n);
      int n = 0;
      idle();
      for (int i = 0; i < 6; i++) begin
         s_send_c = 1; s_svc_c = vc;
         tick(rq, rq);
         n += int'(c_acc);
      end
      idle();
      chk(rq, 8'(n), 8'(exp_n));
   endtask

   task automatic stream_o(input logic vc, input string rq, input int exp_n);
      int n = 0;
      idle();
      for (int i = 0; i < 8; i++) begin
         s_send_o = 1; s_svc_o = vc;
         tick(rq, rq);
         n += int'(o_acc);
      end
      idle();
      chk(rq, 8'(n), 8'(exp_n));
   endtask

   task automatic credit_stream(input int dly, input string rq, output int n);
      int due [64];
      n = 0;
      for (int i = 0; i < 64; i++) due[i] = 0;
      for (int t = 0; t < 40; t++) begin
         idle();
         s_send_c = 1; s_svc_c = 0;
         if (due[t] != 0) begin s_cred_c = 1; s_cvc_c = 0; end
         tick(rq, rq);
         if (c_acc) begin n++; due[t + dly] = 1; end
      end
      idle();
   endtask

   initial begin
      int n;
      int outst [3];
      do_reset();
      // R1: reset state on both instances
      tick("R1", "R1");
      chk("R1", {5'b0, can_c}, 8'h07);

      // R3 R2: exhaust VC0, then extra sends are ignored
      drain_c(2'd0, "R3", CD);
      drain_c(2'd0, "R3", 0);
      // R3: an out-of-range VC number touches nothing
      idle(); s_send_c = 1; s_svc_c = 2'd3; tick("R3", "R3"); idle();
      drain_c(2'd2, "R3", CD);

      // R4: one credit returns to VC0 through the return stage
      idle(); s_cred_c = 1; s_cvc_c = 0; tick("R4", "R4");
      idle(); tick("R4", "R4");
      chk("R4", {7'b0, can_c[0]}, 8'h00);
      tick("R4", "R4");
      chk("R4", {7'b0, can_c[0]}, 8'h01);

      // R5: credit lands on VC0 in the cycle VC0 sends -> still 1 slot
      idle(); s_cred_c = 1; s_cvc_c = 0; tick("R5", "R5");
      idle(); s_send_c = 1; s_svc_c = 0; tick("R5", "R5");
      drain_c(2'd0, "R5", 1);
      // R5: different VCs: credit to VC0 while VC1 sends
      idle(); s_cred_c = 1; s_cvc_c = 0; tick("R5", "R5");
      idle(); s_send_c = 1; s_svc_c = 1; tick("R5", "R5");
      idle(); tick("R5", "R5");
      drain_c(2'd0, "R5", 1);
      drain_c(2'd1, "R5", CD - 1);

      // R6: full counter plus simultaneous send -> no overflow
      do_reset();
      idle(); s_cred_c = 1; s_cvc_c = 1; tick("R6", "R6");
      idle(); s_send_c = 1; s_svc_c = 1; tick("R6", "R6");
      idle(); tick("R6", "R6");
      chk("R6", {7'b0, ovf_c}, 8'h00);
      drain_c(2'd1, "R6", CD);
      // R6: credit into a full counter sets the sticky flag
      idle(); s_cred_c = 1; s_cvc_c = 2; tick("R6", "R6");
      idle(); tick("R6", "R6"); tick("R6", "R6");
      chk("R6", {7'b0, ovf_c}, 8'h01);
      drain_c(2'd2, "R6", CD);
      repeat (4) tick("R6", "R6");
      chk("R6", {7'b0, ovf_c}, 8'h01);

      // R10: credit loop within LINK_RTT never stalls
      do_reset();
      credit_stream(1, "R10", n);
      chk("R10", 8'(n), 8'd40);
      // R10: loop one cycle longer than the depth stalls: 3 per 4 cycles
      do_reset();
      credit_stream(2, "R10", n);
      chk("R10", 8'(n), 8'd30);

      // R2 R3 R4 R5: long sweep with legal credits only
      do_reset();
      for (int v = 0; v < 3; v++) outst[v] = 0;
      for (int t = 0; t < 600; t++) begin
         automatic int unsigned r = rnd();
         idle();
         s_send_c = r[0] | r[1];
         s_svc_c  = 2'(r[3:2] == 3 ? 0 : r[3:2]);
         s_cvc_c  = 2'(r[5:4] == 3 ? 2 : r[5:4]);
         s_cred_c = r[6] && (outst[s_cvc_c] > 0);
         if (s_cred_c) outst[s_cvc_c]--;
         tick("R2", "R7");
         if (c_acc) outst[svc_c]++;
      end
      idle();
      chk("R6", {7'b0, ovf_c}, 8'h00);

      // stop/go side
      do_reset();
      tick("R1", "R1");
      chk("R1", {6'b0, can_o}, 8'h03);
      // R9: undrained stream gets OFF_LEVEL + RET_STAGES flits
      stream_o(1'b0, "R9", OFF + 1);
      chk("R9", {6'b0, can_o}, 8'h02);
      // R8: one drain leaves fill at the off level, still stopped
      idle(); s_drain = 1; s_dvc = 0; tick("R8", "R8");
      idle(); tick("R8", "R8"); tick("R8", "R8");
      chk("R8", {7'b0, can_o[0]}, 8'h00);
      // R8: second drain drops below the level, go after one stage
      idle(); s_drain = 1; s_dvc = 0; tick("R8", "R8");
      idle(); tick("R8", "R8");
      chk("R8", {7'b0, can_o[0]}, 8'h00);
      tick("R8", "R8");
      chk("R8", {7'b0, can_o[0]}, 8'h01);
      // R8: drains of an empty VC are ignored
      idle(); s_drain = 1; s_dvc = 1; tick("R8", "R8"); tick("R8", "R8");
      stream_o(1'b1, "R8", OFF + 1);
      // R7: stray credits and sends while stopped change nothing
      for (int i = 0; i < 6; i++) begin
         idle(); s_cred_o = 1; s_cvc_o = 1'(i); s_send_o = 1; s_svc_o = 1;
         tick("R7", "R7");
      end
      idle();
      chk("R7", {6'b0, can_o}, 8'h01);
      // R7 R8: sweep with random launches and drains
      for (int t = 0; t < 600; t++) begin
         automatic int unsigned r = rnd();
         idle();
         s_send_o = r[0]; s_svc_o = r[1];
         s_drain = r[2] | r[3]; s_dvc = r[4];
         s_cred_o = r[5]; s_cvc_o = r[6];
         tick("R2", "R7");
      end
      idle();
      repeat (2) tick("R2", "R8");

      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule